// File: doc/BRIEF.md
# Serial/Parallel Fall-Through FIFO

This block is a first-in first-out buffer of sixteen 4-bit words. A word enters through an input register and falls through a 14-location stack to an output register. Both end registers can be used either 4 bits at a time or one bit at a time. On the write side, a word is loaded in parallel or shifted in serially. A low request then moves the word into the stack, and an active-low full flag shows whether the input register is occupied. On the read side, a high parallel-transfer request loads the oldest word into the output register and raises a valid flag. Alternatively, a serial request lets a falling-edge output clock shift the word out one bit at a time.

All control inputs are asynchronous to the system clock. Each passes through a two-stage synchronizer. The two serial clocks act on their falling edges, which are detected in the system clock domain. The master reset is synchronous and active low. It reinitializes the control state (flags, interlocks and stack occupancy) but leaves stored data in place. The parallel output drive is shown as an enable signal instead of a tri-state pin.

Top module: `sp_fifo`

## Requirements
- R1: After master reset, full_no is 1, out_valid_o is 0 and ser_out_en_o is 0.
- R2: While pload_i is high, the input register takes din_i and full_no goes low.
- R3: With pload_i low, ser_en_ni low and the register not full, each falling edge of sclk_in_i shifts in one bit from ser_in_i. The first bit shifted ends in bit 0 and the fourth in bit 3. full_no goes low only after the fourth bit. Further falling edges leave the word unchanged.
- R4: When xfer_in_ni is low, the register is full and the top stack location is free, the word enters the stack exactly once. full_no returns high only once pload_i is low. Holding xfer_in_ni low never enters the same word twice.
- R5: The buffer holds 16 words: 14 in the stack, one in the output register and one in the input register. With the stack full, a transfer request leaves full_no low. The request completes by itself once a location frees.
- R6: A high level on xfer_out_par_i loads the oldest word into q_o and sets out_valid_o, at most once per high level. When the request goes low, out_valid_o clears and q_o keeps the word.
- R7: A high level on xfer_out_par_i while the buffer is empty leaves out_valid_o low.
- R8: When the word is loaded with xfer_out_ser_ni low, ser_out_en_o goes high and ser_out_o shows bit 0. Each falling edge of sclk_out_i presents the next higher bit. The fourth falling edge clears ser_out_en_o and out_valid_o.
- R9: q_drv_o is high exactly when oe_ni is low.
- R10: Master reset leaves the word in the output register unchanged on q_o and empties the stack.
- R11: Words leave in the order they were entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| pload_i | input | 1 | Parallel load of the input register, active high |
| din_i | input | 4 | Parallel input word |
| ser_in_i | input | 1 | Serial input bit |
| ser_en_ni | input | 1 | Serial entry enable, active low |
| sclk_in_i | input | 1 | Serial input clock, falling edge |
| xfer_in_ni | input | 1 | Transfer-to-stack request, active low |
| full_no | output | 1 | Input register full, active low |
| xfer_out_par_i | input | 1 | Output transfer request, active high |
| xfer_out_ser_ni | input | 1 | Serial output mode select, active low |
| sclk_out_i | input | 1 | Serial output clock, falling edge |
| oe_ni | input | 1 | Parallel output enable, active low |
| q_o | output | 4 | Output register word |
| q_drv_o | output | 1 | Parallel outputs driven |
| out_valid_o | output | 1 | Output register holds a fresh word |
| ser_out_o | output | 1 | Serial output bit |
| ser_out_en_o | output | 1 | Serial output enabled |

## Verification
Words move through the buffer with every combination of parallel or serial entry and parallel or serial extraction. Serial entry and extraction show whether bit order is kept at each end. Parallel use isolates the handshakes. A directed fill to sixteen words, with the transfer request held low, separates the blocked transfer from the deferred one. It also separates one load per level from repeated loads. Pulses on an empty buffer, extra serial clocks after the fourth bit, and a reset with a word held in the output register each test a case where an input must have no effect on the data.

// File: rtl/sp_fifo_pkg.sv
// Shared sizes for the serial/parallel fall-through FIFO.
package sp_fifo_pkg;
    localparam int unsigned WORD_W  = 4;   // bits per word
    localparam int unsigned STACK_D = 14;  // fall-through locations
endpackage

// File: rtl/sp_sync.sv
// Two-stage synchronizer for a vector of asynchronous level inputs.
// Assumes each bit is sampled independently; callers keep related bits stable.
module sp_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // Purpose: move one bit into the clock domain over two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_i[i];
                s2 <= s1;
            end
        end
        assign q_o[i] = s2;
    end
endmodule

// File: rtl/sp_in_reg.sv
// Input register with marker-bit serial completion and a one-shot stack transfer.
// Assumes synchronized controls and a one-cycle falling-edge strobe for the serial clock.
module sp_in_reg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pload,
    input  logic [W-1:0] din,
    input  logic         ser_in,
    input  logic         ser_en_n,
    input  logic         sclk_fall,
    input  logic         xfer_n,
    input  logic         top_free,
    output logic         push,
    output logic [W-1:0] word,
    output logic         full_n
);
    localparam logic [W-1:0] MARK = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] ir;
    logic         full;
    logic         req;

    assign push   = !xfer_n && full && top_free && !req;
    assign word   = ir;
    assign full_n = !full;

    // Purpose: parallel load, serial shift, and re-initialization after a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir   <= MARK;
            full <= 1'b0;
            req  <= 1'b0;
        end else begin
            if (pload) begin
                ir   <= din;
                full <= 1'b1;
            end else if (req) begin
                ir   <= MARK;
                full <= 1'b0;
                req  <= 1'b0;
            end else if (sclk_fall && !ser_en_n && !full) begin
                full <= ir[0];
                ir   <= {ser_in, ir[W-1:1]};
            end
            if (push) begin
                req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_stack.sv
// Fall-through stack: each word moves one location per clock toward the bottom
// whenever the next location is empty. Data is never reset, occupancy is.
module sp_stack #(
    parameter int unsigned W = 4,
    parameter int unsigned D = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         top_free,
    output logic         bot_vld,
    output logic [W-1:0] bot_data
);
    logic [D-1:0] vld;
    logic [D-1:0] move;
    logic [W-1:0] mem [D];

    assign top_free = !vld[0];
    assign bot_vld  = vld[D-1];
    assign bot_data = mem[D-1];

    for (genvar i = 0; i < D; i++) begin : g_loc
        if (i == D - 1) begin : g_last
            assign move[i] = pop;
        end else begin : g_mid
            assign move[i] = vld[i] && !vld[i+1];
        end

        if (i == 0) begin : g_top
            // Purpose: top location accepts pushes from the input register.
            always_ff @(posedge clk) begin
                if (!rst_n) vld[i] <= 1'b0;
                else        vld[i] <= (vld[i] && !move[i]) || push;
                if (push)   mem[i] <= push_data;
            end
        end else begin : g_low
            // Purpose: lower location takes the word falling from above.
            always_ff @(posedge clk) begin
                if (!rst_n)     vld[i] <= 1'b0;
                else            vld[i] <= (vld[i] && !move[i]) || move[i-1];
                if (move[i-1])  mem[i] <= mem[i-1];
            end
        end
    end
endmodule

// File: rtl/sp_out_reg.sv
// Output register: level-sensitive parallel load with a one-per-level lock,
// optional serial shift-out that empties the register after W bits.
module sp_out_reg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par,
    input  logic         ser_n,
    input  logic         sclk_fall,
    input  logic         bot_vld,
    input  logic [W-1:0] bot_data,
    output logic         pop,
    output logic [W-1:0] q,
    output logic         valid,
    output logic         ser_en
);
    localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  oreg;
    logic          lock;
    logic [CW-1:0] cnt;

    assign pop = par && !lock && bot_vld && !ser_en;
    assign q   = oreg;

    // Purpose: control flags for load, serial shift and release of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            ser_en <= 1'b0;
            lock   <= 1'b0;
            cnt    <= '0;
        end else if (pop) begin
            valid  <= 1'b1;
            lock   <= 1'b1;
            ser_en <= !ser_n;
            cnt    <= '0;
        end else if (ser_en && sclk_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                ser_en <= 1'b0;
                valid  <= 1'b0;
            end
        end else if (!par) begin
            lock <= 1'b0;
            if (!ser_en) valid <= 1'b0;
        end
    end

    // Purpose: data path of the output register, kept through reset.
    always_ff @(posedge clk) begin
        if (pop)                      oreg <= bot_data;
        else if (ser_en && sclk_fall) oreg <= oreg >> 1;
    end
endmodule

// File: rtl/sp_fifo.sv
// Top of the serial/parallel fall-through FIFO. Synchronizes all control
// inputs, detects serial clock falling edges, and wires the three stages.
// The output enable is combinational and only reported, not used as tri-state.
module sp_fifo
    import sp_fifo_pkg::*;
#(
    parameter int unsigned W = WORD_W,
    parameter int unsigned D = STACK_D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pload_i,
    input  logic [W-1:0] din_i,
    input  logic         ser_in_i,
    input  logic         ser_en_ni,
    input  logic         sclk_in_i,
    input  logic         xfer_in_ni,
    output logic         full_no,
    input  logic         xfer_out_par_i,
    input  logic         xfer_out_ser_ni,
    input  logic         sclk_out_i,
    input  logic         oe_ni,
    output logic [W-1:0] q_o,
    output logic         q_drv_o,
    output logic         out_valid_o,
    output logic         ser_out_o,
    output logic         ser_out_en_o
);
    localparam int unsigned SW = W + 8;

    logic [SW-1:0] raw, syn;
    logic          sclk_in_s, sclk_out_s, sclk_in_d, sclk_out_d;
    logic          pload_s, par_s;
    logic          in_fall, out_fall;
    logic          push, top_free, pop, bot_vld;
    logic [W-1:0]  in_word, bot_data;

    assign raw = {din_i, ser_in_i, ser_en_ni, pload_i, sclk_in_i,
                  xfer_in_ni, xfer_out_par_i, xfer_out_ser_ni, sclk_out_i};

    sp_sync #(.W(SW)) sync_i (.clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

    assign sclk_out_s = syn[0];
    assign par_s      = syn[2];
    assign sclk_in_s  = syn[4];
    assign pload_s    = syn[5];

    // Purpose: previous clock levels for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_in_d  <= 1'b0;
            sclk_out_d <= 1'b0;
        end else begin
            sclk_in_d  <= sclk_in_s;
            sclk_out_d <= sclk_out_s;
        end
    end

    assign in_fall  = sclk_in_d && !sclk_in_s;
    assign out_fall = sclk_out_d && !sclk_out_s;

    sp_in_reg #(.W(W)) in_i (
        .clk(clk), .rst_n(rst_n), .pload(pload_s), .din(syn[SW-1:8]),
        .ser_in(syn[7]), .ser_en_n(syn[6]), .sclk_fall(in_fall),
        .xfer_n(syn[3]), .top_free(top_free), .push(push),
        .word(in_word), .full_n(full_no)
    );

    sp_stack #(.W(W), .D(D)) stk_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_word),
        .pop(pop), .top_free(top_free), .bot_vld(bot_vld), .bot_data(bot_data)
    );

    sp_out_reg #(.W(W)) out_i (
        .clk(clk), .rst_n(rst_n), .par(par_s), .ser_n(syn[1]),
        .sclk_fall(out_fall), .bot_vld(bot_vld), .bot_data(bot_data),
        .pop(pop), .q(q_o), .valid(out_valid_o), .ser_en(ser_out_en_o)
    );

    assign ser_out_o = q_o[0];
    assign q_drv_o   = !oe_ni;
endmodule

// File: rtl/sp_fifo_chk.sv
// Checker for sp_fifo, bound to every instance of the top module.
module sp_fifo_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         full_no,
    input logic         out_valid_o,
    input logic         ser_out_en_o,
    input logic [W-1:0] q_o,
    input logic         pload_s,
    input logic         par_s
);
    AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (full_no && !out_valid_o && !ser_out_en_o)); // R1

    AST_REINIT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(full_no)) |-> !$past(pload_s)); // R4

    AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ser_out_en_o && !$past(ser_out_en_o) && !$rose(out_valid_o))
        |-> $stable(q_o)); // R6

    AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(out_valid_o)) |-> $past(par_s)); // R7

    AST_SER_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_en_o |-> out_valid_o); // R8

    AST_SER_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ser_out_en_o)) |-> !out_valid_o); // R8
endmodule

bind sp_fifo sp_fifo_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .full_no(full_no), .out_valid_o(out_valid_o),
    .ser_out_en_o(ser_out_en_o), .q_o(q_o), .pload_s(pload_s), .par_s(par_s)
);

// File: tb/sp_fifo_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic
// against a word queue model.
module sp_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SET = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pload = 1'b0, ser_in = 1'b0, ser_en_n = 1'b1, sclk_in = 1'b0;
    logic xin_n = 1'b1, xpar = 1'b0, xser_n = 1'b1, sclk_out = 1'b0, oe_n = 1'b1;
    logic [3:0] din = '0;
    logic full_n, q_drv, out_valid, ser_out, ser_out_en;
    logic [3:0] q;

    int checks = 0, fails = 0;
    logic [3:0] model[$];
    logic [3:0] w0, w1, w16, held;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .pload_i(pload), .din_i(din), .ser_in_i(ser_in),
        .ser_en_ni(ser_en_n), .sclk_in_i(sclk_in), .xfer_in_ni(xin_n), .full_no(full_n),
        .xfer_out_par_i(xpar), .xfer_out_ser_ni(xser_n), .sclk_out_i(sclk_out),
        .oe_ni(oe_n), .q_o(q), .q_drv_o(q_drv), .out_valid_o(out_valid),
        .ser_out_o(ser_out), .ser_out_en_o(ser_out_en)
    );

    function automatic logic bit_of(input logic [3:0] w, input int i);
        return w[i];
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic par_write(input logic [3:0] d);
        din = d; pload = 1'b1; settle(SET);
        chk("R2 full after load", {3'b0, full_n}, 4'd0);
        xin_n = 1'b0; settle(SET);
        chk("R4 held while pload high", {3'b0, full_n}, 4'd0);
        pload = 1'b0; settle(SET);
        chk("R4 reinit after pload low", {3'b0, full_n}, 4'd1);
        xin_n = 1'b1; settle(SET);
        model.push_back(d);
    endtask

    task automatic pulse_in();
        sclk_in = 1'b1; settle(4); sclk_in = 1'b0; settle(4);
    endtask

    task automatic ser_write(input logic [3:0] d, input logic extra);
        ser_en_n = 1'b0;
        for (int b = 0; b < 4; b++) begin
            ser_in = d[b]; pulse_in();
            chk("R3 marker full flag", {3'b0, full_n}, (b == 3) ? 4'd0 : 4'd1);
        end
        if (extra) begin
            ser_in = ~d[0]; pulse_in();
            chk("R3 extra clock ignored", {3'b0, full_n}, 4'd0);
        end
        ser_en_n = 1'b1;
        xin_n = 1'b0; settle(SET);
        chk("R4 reinit after serial transfer", {3'b0, full_n}, 4'd1);
        xin_n = 1'b1; settle(SET);
        model.push_back(d);
    endtask

    task automatic par_read();
        logic [3:0] e;
        e = model.pop_front();
        xpar = 1'b1; settle(SET);
        chk("R6 valid on load", {3'b0, out_valid}, 4'd1);
        chk("R11 order parallel", q, e);
        xpar = 1'b0; settle(SET);
        chk("R6 valid clears", {3'b0, out_valid}, 4'd0);
        chk("R6 data held", q, e);
    endtask

    task automatic ser_read();
        logic [3:0] e;
        e = model.pop_front();
        xser_n = 1'b0; xpar = 1'b1; settle(SET);
        chk("R8 serial enabled", {3'b0, ser_out_en}, 4'd1);
        for (int b = 0; b < 4; b++) begin
            chk("R8 R11 serial bit", {3'b0, ser_out}, {3'b0, bit_of(e, b)});
            sclk_out = 1'b1; settle(4); sclk_out = 1'b0; settle(4);
        end
        chk("R8 serial disabled", {3'b0, ser_out_en}, 4'd0);
        chk("R8 emptied", {3'b0, out_valid}, 4'd0);
        xpar = 1'b0; xser_n = 1'b1; settle(SET);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0F1F));
        settle(4); rst_n = 1'b1; settle(2);
        chk("R1 full_n", {3'b0, full_n}, 4'd1);
        chk("R1 valid", {3'b0, out_valid}, 4'd0);
        chk("R1 serial en", {3'b0, ser_out_en}, 4'd0);

        // R9 output enable
        oe_n = 1'b1; #1; chk("R9 disabled", {3'b0, q_drv}, 4'd0);
        oe_n = 1'b0; #1; chk("R9 enabled", {3'b0, q_drv}, 4'd1);

        // R7 empty request
        xpar = 1'b1; settle(SET);
        chk("R7 empty pulse", {3'b0, out_valid}, 4'd0);
        xpar = 1'b0; settle(SET);

        // R3 serial entry with extra clock, R8 serial out
        ser_write(4'b1011, 1'b1); settle(20);
        ser_read();

        // R5 capacity and deferred transfer, R6 single load per level
        for (int i = 0; i < 14; i++) par_write(4'($urandom));
        settle(20);
        w0 = model.pop_front();
        xpar = 1'b1; settle(SET);
        chk("R6 first word", q, w0);
        par_write(4'($urandom)); settle(20);
        w16 = 4'($urandom);
        din = w16; pload = 1'b1; settle(SET);
        xin_n = 1'b0; settle(SET); pload = 1'b0; settle(10);
        chk("R5 blocked when stack full", {3'b0, full_n}, 4'd0);
        xpar = 1'b0; settle(SET);
        chk("R6 valid low after release", {3'b0, out_valid}, 4'd0);
        chk("R6 data kept", q, w0);
        w1 = model[0];
        xpar = 1'b1; settle(30);
        chk("R5 deferred transfer done", {3'b0, full_n}, 4'd1);
        chk("R6 one load per level", q, w1);
        chk("R6 still valid", {3'b0, out_valid}, 4'd1);
        xin_n = 1'b1; model.push_back(w16);
        void'(model.pop_front());
        xpar = 1'b0; settle(SET);
        settle(20);
        while (model.size() > 0) par_read();

        // Random mix
        for (int it = 0; it < 160; it++) begin
            if ((model.size() < 14) && ($urandom_range(1, 0) == 1 || model.size() == 0)) begin
                if ($urandom_range(1, 0) == 1) par_write(4'($urandom));
                else ser_write(4'($urandom), 1'($urandom));
                settle(20);
            end else begin
                if ($urandom_range(1, 0) == 1) par_read();
                else ser_read();
            end
        end
        while (model.size() > 0) par_read();

        // R10 reset keeps output word, empties stack
        par_write(4'hA); par_write(4'h5); settle(20);
        par_read();
        held = q;
        par_write(4'h3); settle(20);
        rst_n = 1'b0; settle(3); rst_n = 1'b1; settle(2);
        model.delete();
        chk("R10 data kept through reset", q, held);
        chk("R10 R1 full_n", {3'b0, full_n}, 4'd1);
        chk("R10 valid low", {3'b0, out_valid}, 4'd0);
        xpar = 1'b1; settle(SET);
        chk("R10 stack emptied", {3'b0, out_valid}, 4'd0);
        xpar = 1'b0; settle(SET);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule